// File: doc/BRIEF.md
# Element-Width Polymorphic Register File

This block is a file of 64-bit registers that can also be read and written as packed arrays of narrower elements. Each access names a base register, an element width of 8, 16, 32 or 64 bits, and an element index. Elements are laid out from the least significant byte of the base register upward and run on into the registers above it. As a result, the arrays that start at neighbouring base registers overlap in storage.

The block has three ports. A combinational read port returns one element, zero-extended to 64 bits. A write port commits one element on the rising clock edge. A tag port marks one register per cycle as scalar or vector. A register tagged scalar ignores the requested width and index on writes and takes the whole 64-bit value. A register tagged vector takes only the bytes of the addressed element.

Top module: `ewrf_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and tags every register scalar.
- R2: Width codes are 2'b00 for 8 bits, 2'b01 for 16 bits, 2'b10 for 32 bits and 2'b11 for 64 bits. Read data narrower than 64 bits is zero-extended.
- R3: The element's byte address is base×8 + index×(width/8). Byte address A lives in register A[9:3], starting at bit 8×A[2:0]. An index may therefore reach into registers above the base.
- R4: A write whose base register is tagged scalar stores all 64 bits of the write data into the base register, whatever the width and index.
- R5: A write whose base register is tagged vector changes only the bytes of the addressed element. All other stored bits keep their values.
- R6: A write becomes visible on the read port after the rising edge that takes it. A read of the same element in the same cycle returns the previous contents.
- R7: The tag port sets one register's tag per cycle (1 = vector, 0 = scalar). A write in the same cycle as a tag change still follows the tag held before that edge.
- R8: The byte address wraps modulo 1024, so an element past the top register lands at the bottom of the file.
- R9: With the write enable low, the stored contents and the read data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_base | input | 7 | Read base register |
| rd_ew | input | 2 | Read element width code |
| rd_idx | input | 10 | Read element index |
| rd_data | output | 64 | Read element, zero-extended |
| wr_en | input | 1 | Write enable |
| wr_base | input | 7 | Write base register |
| wr_ew | input | 2 | Write element width code |
| wr_idx | input | 10 | Write element index |
| wr_data | input | 64 | Write data; low bits hold the element |
| tag_we | input | 1 | Tag write enable |
| tag_reg | input | 7 | Register whose tag is set |
| tag_vec | input | 1 | New tag: 1 vector, 0 scalar |

## Verification
Two pairs of operations can fall in the same cycle. The first is a read and a write of the same element. The bench drives both before one edge, expects the old element just before that edge and the new element just after it. The second is a tag change and a data write to the same register. The bench drives both together and judges the stored result against the tag held before the edge. Randomized writes, tags and reads are compared against a 1024-byte reference array and include reads that cross into higher registers and wrap past the top.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;
  typedef enum logic [1:0] {
    EW8  = 2'b00,
    EW16 = 2'b01,
    EW32 = 2'b10,
    EW64 = 2'b11
  } ew_t;
endpackage

// File: rtl/ewrf_locate.sv
// Maps (base register, width, element index) onto one storage word,
// a byte lane inside it and the bit mask the element covers.
module ewrf_locate #(
  parameter int NREGS = 128,
  parameter int XLEN  = 64,
  parameter int OFFW  = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] base,
  input  ewrf_pkg::ew_t            ew,
  input  logic [OFFW-1:0]          idx,
  output logic [$clog2(NREGS)-1:0] word,
  output logic [$clog2(XLEN/8)-1:0] lane,
  output logic [XLEN-1:0]          bmask
);
  import ewrf_pkg::*;
  localparam int BYTES = XLEN / 8;
  localparam int LANEW = $clog2(BYTES);
  localparam int REGW  = $clog2(NREGS);
  localparam int ADDRW = REGW + LANEW;
  localparam int SCW   = OFFW + LANEW;

  logic [SCW-1:0]   idx_scaled;
  logic [ADDRW-1:0] byte_addr;
  logic [XLEN-1:0]  elem_mask;

  always_comb begin
    idx_scaled = SCW'(idx) << ew;
    byte_addr  = {base, {LANEW{1'b0}}} + ADDRW'(idx_scaled);
    word       = byte_addr[ADDRW-1:LANEW];
    lane       = byte_addr[LANEW-1:0];
    if (ew == EW64) elem_mask = '1;
    else            elem_mask = (XLEN'(1) << (8 << ew)) - XLEN'(1);
    bmask      = elem_mask << {lane, 3'b000};
  end

  // R5: the element mask covers exactly the element's bits
  a_r5_mask_width: assert property (@(posedge clk) disable iff (rst)
    $countones(bmask) == (8 << ew));
  // R3: elements are naturally aligned, so one never straddles two words
  a_r3_lane_aligned: assert property (@(posedge clk) disable iff (rst)
    (32'(lane) % (1 << ew)) == 0);
endmodule

// File: rtl/ewrf_extract.sv
// Aligns the addressed element to bit 0 and zero-extends it.
module ewrf_extract #(
  parameter int XLEN = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [XLEN-1:0]           word_data,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  ewrf_pkg::ew_t             ew,
  output logic [XLEN-1:0]           elem
);
  import ewrf_pkg::*;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] keep;

  always_comb begin
    shifted = word_data >> {lane, 3'b000};
    if (ew == EW64) keep = '1;
    else            keep = (XLEN'(1) << (8 << ew)) - XLEN'(1);
    elem = shifted & keep;
  end

  // R2: narrow reads carry zeros above the element
  a_r2_zero_ext8: assert property (@(posedge clk) disable iff (rst)
    (ew == EW8) |-> (elem[XLEN-1:8] == '0));
  a_r2_zero_ext32: assert property (@(posedge clk) disable iff (rst)
    (ew == EW32) |-> (elem[XLEN-1:32] == '0));
endmodule

// File: rtl/ewrf_tag_bank.sv
// Per-register scalar/vector tags, one updated per cycle.
module ewrf_tag_bank #(
  parameter int NREGS = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tag_we,
  input  logic [$clog2(NREGS)-1:0] tag_reg,
  input  logic                     tag_vec,
  input  logic [$clog2(NREGS)-1:0] q_reg,
  output logic                     q_vec
);
  localparam int REGW = $clog2(NREGS);
  logic [NREGS-1:0] vec_tag;

  always_ff @(posedge clk) begin
    if (rst)         vec_tag <= '0;
    else if (tag_we) vec_tag[tag_reg] <= tag_vec;
  end

  assign q_vec = vec_tag[q_reg];

  // R7: a tag write lands in the named register
  a_r7_tag_update: assert property (@(posedge clk) disable iff (rst)
    tag_we |=> (vec_tag[$past(tag_reg)] == $past(tag_vec)));
  // R1: reset leaves every register scalar
  a_r1_tag_reset: assert property (@(posedge clk)
    $past(rst) |-> (vec_tag == '0));
endmodule

// File: rtl/ewrf_regfile.sv
module ewrf_regfile #(
  parameter int NREGS = 128,
  parameter int XLEN  = 64,
  parameter int OFFW  = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] rd_base,
  input  logic [1:0]               rd_ew,
  input  logic [OFFW-1:0]          rd_idx,
  output logic [XLEN-1:0]          rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_base,
  input  logic [1:0]               wr_ew,
  input  logic [OFFW-1:0]          wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     tag_we,
  input  logic [$clog2(NREGS)-1:0] tag_reg,
  input  logic                     tag_vec
);
  import ewrf_pkg::*;
  localparam int REGW  = $clog2(NREGS);
  localparam int LANEW = $clog2(XLEN / 8);

  logic [XLEN-1:0] regs [NREGS];

  // read path
  logic [REGW-1:0]  rd_word;
  logic [LANEW-1:0] rd_lane;
  logic [XLEN-1:0]  rd_mask_unused;

  ewrf_locate #(.NREGS(NREGS), .XLEN(XLEN), .OFFW(OFFW)) u_rd_loc (
    .clk(clk), .rst(rst), .base(rd_base), .ew(ew_t'(rd_ew)), .idx(rd_idx),
    .word(rd_word), .lane(rd_lane), .bmask(rd_mask_unused)
  );

  ewrf_extract #(.XLEN(XLEN)) u_rd_ext (
    .clk(clk), .rst(rst), .word_data(regs[rd_word]), .lane(rd_lane),
    .ew(ew_t'(rd_ew)), .elem(rd_data)
  );

  // write path
  logic [REGW-1:0]  wl_word;
  logic [LANEW-1:0] wl_lane;
  logic [XLEN-1:0]  wl_mask;
  logic             base_is_vec;
  logic [REGW-1:0]  wr_word;
  logic [XLEN-1:0]  wr_mask;
  logic [XLEN-1:0]  wr_shifted;

  ewrf_locate #(.NREGS(NREGS), .XLEN(XLEN), .OFFW(OFFW)) u_wr_loc (
    .clk(clk), .rst(rst), .base(wr_base), .ew(ew_t'(wr_ew)), .idx(wr_idx),
    .word(wl_word), .lane(wl_lane), .bmask(wl_mask)
  );

  ewrf_tag_bank #(.NREGS(NREGS)) u_tags (
    .clk(clk), .rst(rst), .tag_we(tag_we), .tag_reg(tag_reg),
    .tag_vec(tag_vec), .q_reg(wr_base), .q_vec(base_is_vec)
  );

  always_comb begin
    if (base_is_vec) begin
      wr_word    = wl_word;
      wr_mask    = wl_mask;
      wr_shifted = wr_data << {wl_lane, 3'b000};
    end else begin
      wr_word    = wr_base;
      wr_mask    = '1;
      wr_shifted = wr_data;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NREGS; gi++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)
          regs[gi] <= '0;
        else if (wr_en && wr_word == REGW'(gi))
          regs[gi] <= (regs[gi] & ~wr_mask) | (wr_shifted & wr_mask);
      end
    end
  endgenerate

  // R4: a scalar-tagged base takes the whole write value
  a_r4_scalar_full: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !base_is_vec) |=> (regs[$past(wr_base)] == $past(wr_data)));
  // R9: no write and a steady read address leave the read data steady
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(rd_base) && $stable(rd_ew)
     && $stable(rd_idx)) |-> $stable(rd_data));
  // R1: the read port shows zero right after reset
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0));
endmodule

// File: tb/tb_ewrf_regfile.sv
module tb_ewrf_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  rd_base;
  logic [1:0]  rd_ew;
  logic [9:0]  rd_idx;
  logic [63:0] rd_data;
  logic        wr_en;
  logic [6:0]  wr_base;
  logic [1:0]  wr_ew;
  logic [9:0]  wr_idx;
  logic [63:0] wr_data;
  logic        tag_we;
  logic [6:0]  tag_reg;
  logic        tag_vec;

  ewrf_regfile dut (
    .clk(clk), .rst(rst), .rd_base(rd_base), .rd_ew(rd_ew), .rd_idx(rd_idx),
    .rd_data(rd_data), .wr_en(wr_en), .wr_base(wr_base), .wr_ew(wr_ew),
    .wr_idx(wr_idx), .wr_data(wr_data), .tag_we(tag_we), .tag_reg(tag_reg),
    .tag_vec(tag_vec)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  logic [7:0] mem_ref [1024];
  bit         tag_ref [128];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int addr_of(int b, int w, int i);
    return (b * 8 + i * (1 << w)) % 1024;
  endfunction

  function automatic logic [63:0] ref_read(int b, int w, int i);
    logic [63:0] v = '0;
    int a = addr_of(b, w, i);
    for (int k = 0; k < (1 << w); k++) v[8*k +: 8] = mem_ref[a + k];
    return v;
  endfunction

  task automatic ref_write(int b, int w, int i, logic [63:0] d);
    if (!tag_ref[b]) begin
      for (int k = 0; k < 8; k++) mem_ref[b * 8 + k] = d[8*k +: 8];
    end else begin
      int a = addr_of(b, w, i);
      for (int k = 0; k < (1 << w); k++) mem_ref[a + k] = d[8*k +: 8];
    end
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(string req, int b, int w, int i);
    @(negedge clk);
    rd_base = 7'(b); rd_ew = 2'(w); rd_idx = 10'(i);
    #1 check(req, rd_data, ref_read(b, w, i));
  endtask

  task automatic do_write(int b, int w, int i, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_base = 7'(b); wr_ew = 2'(w); wr_idx = 10'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    ref_write(b, w, i, d);
  endtask

  task automatic do_tag(int r, bit v);
    @(negedge clk);
    tag_we = 1'b1; tag_reg = 7'(r); tag_vec = v;
    @(negedge clk);
    tag_we = 1'b0;
    tag_ref[r] = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 1024; k++) mem_ref[k] = 8'h00;
    for (int k = 0; k < 128; k++) tag_ref[k] = 1'b0;
  endtask

  typedef struct packed {
    logic        is_tag;
    logic [6:0]  base;
    logic [1:0]  ew;
    logic [9:0]  idx;
    logic [63:0] data;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 7'd5,   2'd0, 10'd0, 64'd1},
    '{1'b0, 7'd5,   2'd0, 10'd9, 64'h0000_0000_0000_00A5},
    '{1'b0, 7'd5,   2'd1, 10'd7, 64'h0000_0000_0000_BEEF},
    '{1'b0, 7'd3,   2'd1, 10'd4, 64'h1122_3344_5566_7788},
    '{1'b1, 7'd127, 2'd0, 10'd0, 64'd1},
    '{1'b0, 7'd127, 2'd2, 10'd3, 64'h0000_0000_CAFE_F00D},
    '{1'b0, 7'd127, 2'd3, 10'd1, 64'h0123_4567_89AB_CDEF},
    '{1'b1, 7'd20,  2'd0, 10'd0, 64'd1},
    '{1'b0, 7'd20,  2'd2, 10'd5, 64'h0000_0000_DEAD_BEEF},
    '{1'b1, 7'd5,   2'd0, 10'd0, 64'd0},
    '{1'b0, 7'd5,   2'd0, 10'd9, 64'hFFEE_DDCC_BBAA_9977}
  };

  initial begin
    rst = 1'b1; wr_en = 1'b0; tag_we = 1'b0;
    rd_base = '0; rd_ew = '0; rd_idx = '0;
    wr_base = '0; wr_ew = '0; wr_idx = '0; wr_data = '0;
    tag_reg = '0; tag_vec = 1'b0;
    do_reset();

    // R1: every register reads zero after reset
    for (int r = 0; r < 128; r += 9) do_read("R1 reset zero", r, 3, 0);

    // table walk: R3, R4, R5, R8
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].is_tag) begin
        do_tag(int'(VECS[v].base), VECS[v].data[0]);
      end else begin
        int b = int'(VECS[v].base);
        int w = int'(VECS[v].ew);
        int i = int'(VECS[v].idx);
        int wd = tag_ref[b] ? addr_of(b, w, i) / 8 : b;
        do_write(b, w, i, VECS[v].data);
        do_read("R3 element readback", b, w, i);
        do_read("R4/R5 word contents", wd, 3, 0);
        do_read("R5 next word untouched", (wd + 1) % 128, 3, 0);
        do_read("R8 wrap neighbour", (wd + 127) % 128, 3, 0);
      end
    end

    // R2: zero extension of narrow reads from a full word
    do_write(40, 3, 0, 64'hF1E2_D3C4_B5A6_9788);
    do_read("R2 8-bit", 40, 0, 7);
    do_read("R2 16-bit", 40, 1, 2);
    do_read("R2 32-bit", 40, 2, 1);

    // R6: same-cycle read and write of one element
    do_tag(50, 1'b1);
    do_write(50, 1, 1, 64'h0000_0000_0000_1234);
    @(negedge clk);
    wr_en = 1'b1; wr_base = 7'd50; wr_ew = 2'd1; wr_idx = 10'd1;
    wr_data = 64'h0000_0000_0000_ABCD;
    rd_base = 7'd50; rd_ew = 2'd1; rd_idx = 10'd1;
    #1 check("R6 old value before edge", rd_data, 64'h1234);
    @(negedge clk);
    wr_en = 1'b0;
    ref_write(50, 1, 1, 64'hABCD);
    #1 check("R6 new value after edge", rd_data, 64'hABCD);

    // R9: write fields driven with enable low
    @(negedge clk);
    wr_en = 1'b0; wr_base = 7'd50; wr_ew = 2'd3; wr_idx = 10'd0;
    wr_data = 64'hDEAD_DEAD_DEAD_DEAD;
    @(negedge clk);
    do_read("R9 disabled write ignored", 50, 3, 0);

    // R7: tag change and write in the same cycle use the old tag
    @(negedge clk);
    tag_we = 1'b1; tag_reg = 7'd60; tag_vec = 1'b1;
    wr_en = 1'b1; wr_base = 7'd60; wr_ew = 2'd0; wr_idx = 10'd3;
    wr_data = 64'h5555_6666_7777_8888;
    @(negedge clk);
    tag_we = 1'b0; wr_en = 1'b0;
    ref_write(60, 0, 3, 64'h5555_6666_7777_8888);
    tag_ref[60] = 1'b1;
    do_read("R7 old tag governs write", 60, 3, 0);
    do_write(60, 0, 3, 64'h0000_0000_0000_0011);
    do_read("R7 new tag applies next", 60, 3, 0);

    // random mix against the reference array: R3, R4, R5, R8
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 5));
      int b  = int'($urandom_range(0, 127));
      int w  = int'($urandom_range(0, 3));
      int i  = int'($urandom_range(0, 1023));
      if (op == 0) do_tag(b, 1'($urandom_range(0, 1)));
      else if (op < 3) do_write(b, w, i, {$urandom, $urandom});
      else do_read("R3/R5/R8 random read", b, w, i);
    end

    // R1: reset mid-run clears data and restores scalar tags
    do_reset();
    do_read("R1 cleared after reset", 20, 3, 0);
    do_write(20, 0, 5, 64'hAAAA_BBBB_CCCC_DDDD);
    do_read("R1 tag scalar after reset", 20, 3, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule